// File: doc/BRIEF.md
# Buffered 16-bit Timer Peripheral

This block is a 16-bit up-counter on an 8-bit register bus. Software reaches it through four byte addresses: a control register, the low and high bytes of the count, and an interrupt register. The count is split over two bytes, so a plain two-read sequence can return a torn value if a carry ripples between the reads. To avoid this, a wide-access mode routes every high-byte access through a holding byte. Reading the low byte copies the live high byte into that holding byte. Writing the low byte moves the holding byte into the live high byte in the same cycle.

The count advances on prescaled ticks. A tick comes either from the system clock or from rising edges of an external input, which is first brought into the system clock domain. Passing 0xFFFF sets a sticky overflow flag, and the flag drives an interrupt line through an enable bit. A trigger pulse from a neighbouring compare unit clears the count, which lets that unit set the period. A bus write to a count byte overrides a trigger in the same cycle.

Top module: `tmr16_buffered`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low. Address map: 0 control, 1 count low, 2 count high, 3 interrupt.
- R2: With the on bit (control bit 0) set, the internal source selected (control bit 1 = 0) and divide-by-1, the count rises by one every cycle. With the on bit clear, the count holds.
- R3: The prescale field (control bits 5:4) values 00, 01, 10 and 11 give one count per 1, 2, 4 and 8 ticks.
- R4: When the wide-mode bit (control bit 7) is set, reading address 1 copies the live high byte into the holding byte, and reading address 2 returns the holding byte, not the live high byte.
- R5: In wide mode, writing address 2 changes only the holding byte and leaves the count unchanged. Writing address 1 loads the low byte from the bus and the high byte from the holding byte in the same cycle.
- R6: With wide mode clear, address 2 reads and writes the live high byte directly.
- R7: A write to address 1 restarts the prescaler. A write to address 2 leaves the prescaler phase as it is.
- R8: A step from 0xFFFF to 0x0000 sets interrupt bit 0 (the flag). The flag stays set until software writes 0 to it. Bit 1 of the interrupt register is the enable bit.
- R9: `irq` is high exactly when both the flag and the enable bit are set.
- R10: A `trig` pulse clears the count to 0x0000 and does not set the flag, even when the count is 0xFFFF.
- R11: When a write to address 1 or 2 falls in the same cycle as `trig`, the write takes effect and the trigger clear is dropped.
- R12: With control bit 1 set, the count advances once per rising edge of `ext_clk`, after a two-flop synchroniser. Control bit 2 is a stored, readable synchronisation select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_clk | input | 1 | External count source, asynchronous |
| trig | input | 1 | Compare-match clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is run from an exact zero start under each of the four divide ratios. The count after a fixed number of ticks separates the ratios and shows whether stopping is handled on the right edge. The prescaler-restart checks place bus writes at chosen prescaler phases, so a stray restart on a high-byte write, or a missing restart on a low-byte write, changes the final count by one.

The wide-access checks change the live high byte between a low read and a high read, and between a high write and a low write. Only correct use of the holding byte gives the expected bytes in both orders. The trigger checks cover a trigger alone at 0xFFFF (the flag must stay clear) and a trigger that collides with low-byte and high-byte writes.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_LO   = 2'd1,
        A_HI   = 2'd2,
        A_IRQ  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       wide;
        logic [1:0] div_sel;
        logic       sync_sel;
        logic       src_ext;
        logic       run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.wide     = b[7];
        c.div_sel  = b[5:4];
        c.sync_sel = b[2];
        c.src_ext  = b[1];
        c.run      = b[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {c.wide, 1'b0, c.div_sel, 1'b0, c.sync_sel, c.src_ext, c.run};
    endfunction

    function automatic logic [BYTE_W-1:0] div_mask(input logic [1:0] sel);
        return BYTE_W'((1 << sel) - 1);
    endfunction

endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler
    import tmr16_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       tick,
    input  logic [1:0] div_sel,
    output logic       pulse
);
    logic [PSC_W-1:0]  phase_q;
    logic [BYTE_W-1:0] mask_full;
    logic [PSC_W-1:0]  mask;

    assign mask_full = div_mask(div_sel);
    assign mask      = mask_full[PSC_W-1:0];
    assign pulse     = tick && !clear && (phase_q == mask);

    always_ff @(posedge clk) begin
        if (rst)        phase_q <= '0;
        else if (clear) phase_q <= '0;
        else if (tick)  phase_q <= pulse ? '0 : phase_q + PSC_W'(1);
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              trig,
    input  logic              wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] hold,
    output logic              wrap
);
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hold_q;
    logic              any_wr;
    logic              live_wr;
    logic              clr_eff;
    logic              adv;

    assign any_wr  = wr_lo | wr_hi;
    assign live_wr = wr_lo | (wr_hi & ~wide);
    assign clr_eff = trig & ~any_wr;
    assign adv     = inc & ~live_wr & ~clr_eff;
    assign wrap    = adv & (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            if (clr_eff)  cnt_q <= '0;
            else if (adv) cnt_q <= cnt_q + CNT_W'(1);

            if (wr_lo) begin
                cnt_q[BYTE_W-1:0] <= wdata;
                if (wide) cnt_q[CNT_W-1:BYTE_W] <= hold_q;
            end
            if (wr_hi) begin
                if (wide) hold_q <= wdata;
                else      cnt_q[CNT_W-1:BYTE_W] <= wdata;
            end
            if (rd_lo && wide) hold_q <= cnt_q[CNT_W-1:BYTE_W];
        end
    end

    assign count = cnt_q;
    assign hold  = hold_q;
endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered
    import tmr16_pkg::*;
#(
    parameter int PSC_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic              trig,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              ovf_flag;
    logic              irq_en;
    logic              ext_rise;
    logic              tick;
    logic              step;
    logic              wrap;
    logic [CNT_W-1:0]  count_val;
    logic [BYTE_W-1:0] hold_val;
    logic              wide_mode;
    logic              run_on;
    logic              wr_ctrl, wr_lo, wr_hi, wr_irq, rd_lo;
    reg_addr_e         addr_e;

    assign addr_e    = reg_addr_e'(bus_addr);
    assign wr_ctrl   = bus_wr && addr_e == A_CTRL;
    assign wr_lo     = bus_wr && addr_e == A_LO;
    assign wr_hi     = bus_wr && addr_e == A_HI;
    assign wr_irq    = bus_wr && addr_e == A_IRQ;
    assign rd_lo     = bus_rd && addr_e == A_LO;
    assign wide_mode = ctrl_q.wide;
    assign run_on    = ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_from_byte(bus_wdata);
    end

    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (ext_clk),
        .rise_pulse (ext_rise)
    );

    assign tick = ctrl_q.run && (ctrl_q.src_ext ? ext_rise : 1'b1);

    tmr16_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .clear   (wr_lo),
        .tick    (tick),
        .div_sel (ctrl_q.div_sel),
        .pulse   (step)
    );

    tmr16_core u_core (
        .clk   (clk),
        .rst   (rst),
        .inc   (step),
        .trig  (trig),
        .wide  (ctrl_q.wide),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .rd_lo (rd_lo),
        .wdata (bus_wdata),
        .count (count_val),
        .hold  (hold_val),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            irq_en   <= 1'b0;
        end else begin
            if (wr_irq) begin
                ovf_flag <= bus_wdata[0];
                irq_en   <= bus_wdata[1];
            end
            if (wrap) ovf_flag <= 1'b1;
        end
    end

    assign irq = ovf_flag & irq_en;

    always_comb begin
        unique case (addr_e)
            A_CTRL:  bus_rdata = ctrl_to_byte(ctrl_q);
            A_LO:    bus_rdata = count_val[BYTE_W-1:0];
            A_HI:    bus_rdata = ctrl_q.wide ? hold_val : count_val[CNT_W-1:BYTE_W];
            default: bus_rdata = {{(BYTE_W-2){1'b0}}, irq_en, ovf_flag};
        endcase
    end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic        trig,
    input logic        irq,
    input logic [15:0] count_val,
    input logic        ovf_flag,
    input logic        wide_mode,
    input logic        run_on
);
    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_on && !trig && !bus_wr) |=> $stable(count_val));

    // R5
    wide_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && wide_mode && !run_on && !trig) |=> $stable(count_val));

    // R6
    narrow_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && !wide_mode) |=> count_val[15:8] == $past(bus_wdata));

    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(count_val) == 16'hFFFF || $past(bus_wr && bus_addr == 2'd3)));

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3 && !bus_wdata[1]) |=> !irq);

    // R10
    trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && !bus_wr) |=> count_val == 16'h0000);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> count_val[7:0] == $past(bus_wdata));
endmodule

bind tmr16_buffered tmr16_chk u_chk (.*);

// File: tb/tb_tmr16_buffered.sv
module tb_tmr16_buffered;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       trig = 1'b0;
    logic       irq;

    int compared = 0;
    int mismatched = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    tmr16_buffered dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .trig(trig), .irq(irq)
    );

    task automatic drive(input logic wr, input logic rd, input logic [1:0] a,
                         input logic [7:0] d, input logic t);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; trig = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic wr_trig(input logic [1:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, a, d, 1'b1);
    endtask

    task automatic pulse_trig();
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    endtask

    // driver: push the expectation, then issue the read cycle
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        drive(1'b0, 1'b1, a, 8'h00, 1'b0);
    endtask

    task automatic check_irq(input logic e, input string tag);
        idle(1);
        #3;
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    // monitor: compare read data mid-cycle, away from the edges
    always begin
        @(negedge clk);
        #3;
        if (bus_rd) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL scoreboard: read actual %02h expected none", bus_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 lo");
        rd(2'd2, 8'h00, "R1 hi");
        rd(2'd3, 8'h00, "R1 irqreg");
        check_irq(1'b0, "R1 irq");

        // R6 narrow live high byte
        wr(2'd2, 8'h12); wr(2'd1, 8'h34);
        rd(2'd1, 8'h34, "R6 lo");
        rd(2'd2, 8'h12, "R6 hi");

        // R5 wide writes go through the holding byte
        wr(2'd0, 8'h80); wr(2'd2, 8'hAB);
        wr(2'd0, 8'h00);
        rd(2'd2, 8'h12, "R5 hi untouched");
        wr(2'd0, 8'h80); wr(2'd2, 8'hAB); wr(2'd1, 8'hCD);
        wr(2'd0, 8'h00);
        rd(2'd2, 8'hAB, "R5 hi loaded");
        rd(2'd1, 8'hCD, "R5 lo loaded");

        // R4 low read latches high byte
        wr(2'd2, 8'h56); wr(2'd1, 8'h78);
        wr(2'd0, 8'h80);
        rd(2'd1, 8'h78, "R4 lo");
        wr(2'd0, 8'h00); wr(2'd2, 8'h99);
        rd(2'd2, 8'h99, "R6 live hi");
        wr(2'd0, 8'h80);
        rd(2'd2, 8'h56, "R4 hi from hold");

        // R2 divide-by-1 counting and hold
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'h01); idle(9); wr(2'd0, 8'h00);
        rd(2'd1, 8'h0A, "R2 count");
        idle(5);
        rd(2'd1, 8'h0A, "R2 hold");

        // R3 divide ratios 2, 4, 8 over 16 ticks
        for (int s = 1; s < 4; s++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, {2'b00, 2'(s), 4'b0001});
            idle(15);
            wr(2'd0, 8'h00);
            rd(2'd1, 8'(16 >> s), "R3 ratio");
        end

        // R7 high write keeps prescaler phase (wide, div 2)
        wr(2'd0, 8'h90); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'h91); idle(1); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
        rd(2'd1, 8'h01, "R7 hi keeps phase");

        // R7 low write restarts prescaler (narrow, div 4)
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'h21); idle(1); wr(2'd1, 8'h05); idle(1); wr(2'd0, 8'h00);
        rd(2'd1, 8'h05, "R7 lo restarts");

        // R8 / R9 overflow flag and interrupt
        wr(2'd2, 8'hFF); wr(2'd1, 8'hFE); wr(2'd3, 8'h02);
        wr(2'd0, 8'h01); idle(1); wr(2'd0, 8'h00);
        rd(2'd1, 8'h00, "R8 wrap lo");
        rd(2'd2, 8'h00, "R8 wrap hi");
        rd(2'd3, 8'h03, "R8 flag set");
        check_irq(1'b1, "R9 irq on");
        idle(4);
        rd(2'd3, 8'h03, "R8 sticky");
        wr(2'd3, 8'h02);
        rd(2'd3, 8'h02, "R8 cleared");
        check_irq(1'b0, "R9 flag clear");
        wr(2'd3, 8'h01);
        check_irq(1'b0, "R9 enable clear");
        wr(2'd3, 8'h00);

        // R10 trigger clears without flag
        wr(2'd2, 8'h12); wr(2'd1, 8'h34); pulse_trig();
        rd(2'd1, 8'h00, "R10 lo");
        rd(2'd2, 8'h00, "R10 hi");
        wr(2'd2, 8'hFF); wr(2'd1, 8'hFF); pulse_trig();
        rd(2'd1, 8'h00, "R10 from FFFF");
        rd(2'd3, 8'h00, "R10 no flag");

        // R11 write beats trigger
        wr(2'd2, 8'h12); wr(2'd1, 8'h34);
        wr_trig(2'd1, 8'h77);
        rd(2'd1, 8'h77, "R11 lo");
        rd(2'd2, 8'h12, "R11 hi kept");
        wr_trig(2'd2, 8'h44);
        rd(2'd2, 8'h44, "R11 hi write");
        rd(2'd1, 8'h77, "R11 lo kept");

        // R12 external rising edges
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'h07);
        rd(2'd0, 8'h07, "R12 ctrl readback");
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(4);
        wr(2'd0, 8'h00);
        rd(2'd1, 8'h05, "R12 edges");

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule